// File: doc/BRIEF.md
# Request-driven single-channel transfer controller

This block moves one data unit per peripheral request. Software first loads a source address, a destination address, a transfer count and a mode word, and then sets the enable bit. Each time the peripheral raises its data-ready flag, the block reads one unit from the source and writes it to the destination. It then steps each address as its mode field directs, decrements the count, and pulses a clear strobe back to the peripheral. The CPU is not involved while transfers run.

On the move that brings the count to zero, the block does not pulse the clear strobe, so the peripheral flag stays set. It also clears its own enable bit. The still-pending request then appears on the CPU interrupt output, so the CPU can do the wrap-up work. When the channel is disabled, every request goes straight to the CPU. Typical use is draining a receive data register into a buffer in RAM: the source is held fixed and the destination increments.

Top module: `xfer_ctl`

## Requirements
- R1: After reset, every register reads 0, the channel is disabled, and rd_en, wr_en, per_clr and cpu_irq are all 0.
- R2: The register map is decoded on cfg_addr: 0 is mode, 1 is source, 2 is destination, 3 is count and 4 is control. In the mode register, bits [1:0] hold the source step mode, bits [3:2] hold the destination step mode, and bit 4 is the size bit (0 selects byte, 1 selects word). Bit 0 of the control register is the channel enable. Each written field reads back unchanged on cfg_rdata.
- R3: A register write that arrives while a transfer is in progress is ignored.
- R4: When the channel is enabled and per_req is 1, the block drives rd_en with rd_addr equal to the source address. In the next cycle it drives wr_en with wr_addr equal to the destination address and wr_data equal to rd_data. In byte mode, wr_data is rd_data[7:0] zero-extended and wr_byte is 1. In word mode, wr_data is all 16 bits and wr_byte is 0.
- R5: After each transfer, each address is updated by its 2-bit step mode: 00 and 01 keep it fixed, 10 adds the step, 11 subtracts the step. The step is 1 for byte size and 2 for word size, and addresses wrap modulo 2^24.
- R6: The count decreases by one per transfer. A loaded count of 0 means 2^CNT_W transfers.
- R7: After a transfer that is not the last, per_clr pulses for one cycle, the channel stays enabled, and cpu_irq stays 0.
- R8: After the last transfer, per_clr is not pulsed, the enable bit clears, the count reads 0, and cpu_irq is 1 for as long as per_req stays high.
- R9: A request that arrives while the channel is disabled drives cpu_irq in the same cycle and starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| per_req | input | 1 | Peripheral data-ready flag |
| per_clr | output | 1 | One-cycle clear of the peripheral flag |
| rd_en | output | 1 | Source read strobe |
| rd_addr | output | 24 | Source read address |
| rd_data | input | 16 | Read data, valid the cycle after rd_en |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | 24 | Destination write address |
| wr_data | output | 16 | Destination write data |
| wr_byte | output | 1 | 1 for a byte write, 0 for a word write |
| cpu_irq | output | 1 | Interrupt request passed on to the CPU |

## Verification
The bench goes after the final transfer of a block. A design that off-by-ones the end test would either clear the flag on the last move and lose the CPU interrupt, or stop one transfer early. A zero count load is run to completion; a design that treats 0 literally would finish at once and raise the interrupt without moving any data. Random runs use all step modes and sizes with addresses near the 2^24 boundary, which exposes a wrong step width or a wrap error. Two directed cases check that requests while disabled go straight to the CPU and that a register write during a transfer leaves the count untouched.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WRITE  = 3'd2,
    ST_UPDATE = 3'd3,
    ST_FINISH = 3'd4
  } xfer_state_e;

  localparam logic [2:0] REG_MODE = 3'd0;
  localparam logic [2:0] REG_SRC  = 3'd1;
  localparam logic [2:0] REG_DST  = 3'd2;
  localparam logic [2:0] REG_CNT  = 3'd3;
  localparam logic [2:0] REG_CTRL = 3'd4;

  localparam logic [1:0] STEP_UP   = 2'b10;
  localparam logic [1:0] STEP_DOWN = 2'b11;

  // Next address for a 24-bit pointer; word size steps by two.
  function automatic logic [23:0] next_addr(input logic [23:0] cur,
                                            input logic [1:0]  how,
                                            input logic        word);
    logic [23:0] step;
    step = word ? 24'd2 : 24'd1;
    case (how)
      STEP_UP:   next_addr = cur + step;
      STEP_DOWN: next_addr = cur - step;
      default:   next_addr = cur;
    endcase
  endfunction

endpackage

// File: rtl/xfer_regs.sv
module xfer_regs
  import xfer_pkg::*;
#(
  parameter int AW    = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             busy,
  input  logic             upd,
  input  logic             fin,
  input  logic [AW-1:0]    src_nxt,
  input  logic [AW-1:0]    dst_nxt,
  output logic [4:0]       mode,
  output logic [AW-1:0]    src,
  output logic [AW-1:0]    dst,
  output logic [CNT_W-1:0] cnt,
  output logic             en,
  output logic [31:0]      rdata
);

  logic wr_ok;
  assign wr_ok = we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      src  <= '0;
      dst  <= '0;
      cnt  <= '0;
      en   <= 1'b0;
    end else begin
      if (upd) begin
        src <= src_nxt;
        dst <= dst_nxt;
        cnt <= cnt - 1'b1;
      end
      if (fin) en <= 1'b0;
      if (wr_ok) begin
        case (addr)
          REG_MODE: mode <= wdata[4:0];
          REG_SRC:  src  <= wdata[AW-1:0];
          REG_DST:  dst  <= wdata[AW-1:0];
          REG_CNT:  cnt  <= wdata[CNT_W-1:0];
          REG_CTRL: en   <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_MODE: rdata[4:0]       = mode;
      REG_SRC:  rdata[AW-1:0]    = src;
      REG_DST:  rdata[AW-1:0]    = dst;
      REG_CNT:  rdata[CNT_W-1:0] = cnt;
      REG_CTRL: rdata[0]         = en;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
  import xfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic req,
  input  logic last,
  output logic rd,
  output logic wr,
  output logic upd,
  output logic fin,
  output logic busy
);

  xfer_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (en && req) st_d = ST_READ;
      ST_READ:   st_d = ST_WRITE;
      ST_WRITE:  st_d = ST_UPDATE;
      ST_UPDATE: st_d = last ? ST_FINISH : ST_IDLE;
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign rd   = (st_q == ST_READ);
  assign wr   = (st_q == ST_WRITE);
  assign upd  = (st_q == ST_UPDATE);
  assign fin  = (st_q == ST_FINISH);
  assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/xfer_ctl.sv
module xfer_ctl
  import xfer_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          per_req,
  output logic          per_clr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_byte,
  output logic          cpu_irq
);

  localparam int BYTE_W = 8;

  logic [4:0]       mode;
  logic [AW-1:0]    src, dst, src_nxt, dst_nxt;
  logic [CNT_W-1:0] cnt;
  logic             en, busy, upd, fin, last;
  logic [1:0]       src_mode, dst_mode;
  logic             word;

  assign src_mode = mode[1:0];
  assign dst_mode = mode[3:2];
  assign word     = mode[4];
  assign last     = (cnt == CNT_W'(1));
  assign src_nxt  = next_addr(src, src_mode, word);
  assign dst_nxt  = next_addr(dst, dst_mode, word);

  xfer_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .busy(busy), .upd(upd), .fin(fin), .src_nxt(src_nxt), .dst_nxt(dst_nxt),
    .mode(mode), .src(src), .dst(dst), .cnt(cnt), .en(en), .rdata(cfg_rdata)
  );

  xfer_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .req(per_req), .last(last),
    .rd(rd_en), .wr(wr_en), .upd(upd), .fin(fin), .busy(busy)
  );

  assign rd_addr = src;
  assign wr_addr = dst;
  assign wr_byte = !word;
  assign wr_data = word ? rd_data : {{(DW-BYTE_W){1'b0}}, rd_data[BYTE_W-1:0]};
  assign per_clr = upd && !last;
  assign cpu_irq = per_req && !en && !busy;

endmodule

// File: rtl/xfer_ctl_chk.sv
module xfer_ctl_chk #(
  parameter int AW    = 24,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             busy,
  input logic             upd,
  input logic             fin,
  input logic             rd_en,
  input logic             wr_en,
  input logic             per_clr,
  input logic             per_req,
  input logic             cpu_irq,
  input logic [CNT_W-1:0] cnt,
  input logic [AW-1:0]    src,
  input logic [1:0]       src_mode
);

  AST_WR_AFTER_RD:  assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> $past(rd_en)); // R4
  AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !wr_en && !rd_en); // R4
  AST_SRC_HELD:     assert property (@(posedge clk) disable iff (!rst_n) (upd && !src_mode[1]) |=> $stable(src)); // R5
  AST_CNT_STEP:     assert property (@(posedge clk) disable iff (!rst_n) upd |=> cnt == $past(cnt) - 1'b1); // R6
  AST_CLR_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n) per_clr |=> en); // R7
  AST_FIN_DISABLES: assert property (@(posedge clk) disable iff (!rst_n) fin |=> !en); // R8
  AST_IRQ_GATED:    assert property (@(posedge clk) disable iff (!rst_n) cpu_irq |-> per_req && !en); // R9

endmodule

bind xfer_ctl xfer_ctl_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .busy(busy), .upd(upd), .fin(fin),
  .rd_en(rd_en), .wr_en(wr_en), .per_clr(per_clr), .per_req(per_req),
  .cpu_irq(cpu_irq), .cnt(cnt), .src(src), .src_mode(src_mode)
);

// File: tb/test_xfer_ctl.sv
`timescale 1ns/1ps
module test_xfer_ctl;

  localparam int CW = 8;
  localparam int MAXN = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pflag = 1'b0;
  logic        per_clr, rd_en, wr_en, wr_byte, cpu_irq;
  logic [23:0] rd_addr, wr_addr;
  logic [15:0] rd_data = '0;
  logic [15:0] wr_data;

  int nchk = 0, nbad = 0;
  int wcnt = 0, nexp = 0, clr_seen = 0;
  logic [23:0] exp_a [MAXN];
  logic [15:0] exp_d [MAXN];
  logic        exp_b;

  always #5 clk = ~clk;

  xfer_ctl #(.CNT_W(CW)) i_xfer_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .per_req(pflag),
    .per_clr(per_clr), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_byte(wr_byte),
    .cpu_irq(cpu_irq)
  );

  function automatic logic [15:0] mem_val(input logic [23:0] a);
    return {a[15:8] + a[23:16], a[7:0] ^ 8'h5A};
  endfunction

  function automatic logic [23:0] stepped(input logic [23:0] a, input int m, input int w);
    int d;
    d = (w != 0) ? 2 : 1;
    if (m == 2) return 24'((int'(a) + d) & 32'hFFFFFF);
    if (m == 3) return 24'((int'(a) - d) & 32'hFFFFFF);
    return a;
  endfunction

  // memory model: registered read
  always @(posedge clk) if (rd_en) rd_data <= mem_val(rd_addr);
  // peripheral flag clear
  always @(posedge clk) if (per_clr) pflag <= 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // write monitor, R4
  always @(negedge clk) begin
    if (rst_n) begin
      if (per_clr) clr_seen++;
      if (wr_en) begin
        if (wcnt >= nexp) check("R4/R9 unexpected write", 32'(wr_addr), 32'hFFFFFFFF);
        else begin
          check("R4 write address", 32'(wr_addr), 32'(exp_a[wcnt]));
          check("R4 write data", 32'(wr_data), 32'(exp_d[wcnt]));
          check("R4 write size", 32'(wr_byte), 32'(exp_b));
        end
        wcnt++;
      end
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic run_block(input int sm, input int dm, input int w,
                           input logic [23:0] s0, input logic [23:0] d0,
                           input int cnt, input bit busy_wr);
    int n, c0;
    logic [23:0] s, d;
    logic [31:0] rv;
    n = (cnt == 0) ? (1 << CW) : cnt;
    s = s0; d = d0;
    for (int i = 0; i < n; i++) begin
      exp_a[i] = d;
      exp_d[i] = (w != 0) ? mem_val(s) : {8'h00, mem_val(s)[7:0]};
      s = stepped(s, sm, w);
      d = stepped(d, dm, w);
    end
    exp_b = (w == 0);
    reg_wr(3'd0, 32'((w << 4) | (dm << 2) | sm));
    reg_wr(3'd1, 32'(s0));
    reg_wr(3'd2, 32'(d0));
    reg_wr(3'd3, 32'(cnt));
    wcnt = 0; nexp = n; c0 = clr_seen;
    reg_wr(3'd4, 32'd1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pflag = 1'b1;
      if (busy_wr && i == 0) begin
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'd3; cfg_wdata = 32'h55;
        @(negedge clk); cfg_we = 1'b0;
        repeat (4) @(negedge clk);
      end else repeat (6) @(negedge clk);
      if (i < n - 1) begin
        if (i < 3 || i == n - 2) begin
          check("R7 flag cleared", 32'(pflag), 32'd0);
          check("R7 no irq mid-block", 32'(cpu_irq), 32'd0);
        end
      end else begin
        check("R8 flag kept", 32'(pflag), 32'd1);
        check("R8 irq at end", 32'(cpu_irq), 32'd1);
      end
    end
    check("R4 write count", 32'(wcnt), 32'(n));
    check("R7 clear pulses", 32'(clr_seen - c0), 32'(n - 1));
    reg_rd(3'd4, rv); check("R8 enable cleared", rv, 32'd0);
    reg_rd(3'd3, rv); check("R6 count at zero", rv, 32'd0);
    reg_rd(3'd1, rv); check("R5 final source", rv, 32'(s));
    reg_rd(3'd2, rv); check("R5 final destination", rv, 32'(d));
    @(negedge clk); pflag = 1'b0; #1;
    check("R8 irq follows request", 32'(cpu_irq), 32'd0);
  endtask

  initial begin
    logic [31:0] rv;
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      reg_rd(3'(a), rv); check("R1 register reset", rv, 32'd0);
    end
    check("R1 strobes idle", {28'd0, rd_en, wr_en, per_clr, cpu_irq}, 32'd0);
    // R2 readback
    reg_wr(3'd0, 32'h1B); reg_rd(3'd0, rv); check("R2 mode readback", rv, 32'h1B);
    reg_wr(3'd1, 32'hABCDEF); reg_rd(3'd1, rv); check("R2 source readback", rv, 32'hABCDEF);
    reg_wr(3'd2, 32'h123456); reg_rd(3'd2, rv); check("R2 dest readback", rv, 32'h123456);
    reg_wr(3'd3, 32'h80); reg_rd(3'd3, rv); check("R2 count readback", rv, 32'h80);
    // R9 request while disabled
    nexp = 0; wcnt = 0;
    @(negedge clk); pflag = 1'b1; #1;
    check("R9 irq immediate", 32'(cpu_irq), 32'd1);
    repeat (6) @(negedge clk);
    check("R9 flag untouched", 32'(pflag), 32'd1);
    check("R9 no write", 32'(wcnt), 32'd0);
    pflag = 1'b0;
    // directed: receive-style block, fixed source, incrementing byte dest
    run_block(0, 2, 0, 24'h00FF10, 24'h002000, 16, 1'b0);
    // R3 write while busy, count must not change
    run_block(0, 2, 0, 24'h000040, 24'h003000, 5, 1'b1);
    // single transfer
    run_block(2, 3, 1, 24'hFFFFFF, 24'h000001, 1, 1'b0);
    // wrap both ways with words
    run_block(3, 2, 1, 24'h000002, 24'hFFFFFC, 6, 1'b0);
    // R6 zero load means full count
    run_block(1, 2, 0, 24'h000500, 24'h004000, 0, 1'b0);
    // random blocks
    for (int k = 0; k < 14; k++) begin
      logic [23:0] s0, d0;
      s0 = 24'($urandom);
      d0 = ($urandom % 2) ? 24'($urandom) : 24'hFFFFF8;
      run_block(int'($urandom % 4), int'($urandom % 4), int'($urandom % 2),
                s0, d0, int'($urandom % 12) + 1, 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule